// File: doc/BRIEF.md
# Wide Synchronous Link Flit Framer

This block is the transmit and receive ends of a short, wide inter-switch channel. Both ends run on one clock. Every cycle the channel moves one 16-bit flit, and a 2-bit type field rides beside it on separate control lines. The type field marks each flit as idle, routing tag, payload, or end of packet. The transmit framer takes a stream of words from a packet source and wraps each packet. The first word goes out as the routing tag, the middle words go out as payload, and the word flagged last goes out as the end-of-packet flit. In any cycle with nothing to send, the framer puts an idle flit on the channel.

The receive deframer reads the type field and rebuilds packet boundaries. It stores the flits it keeps in a small buffer, and a sink drains that buffer through a valid/ready handshake. A payload or end-of-packet flit that arrives outside a packet is dropped. A routing tag that arrives in the middle of a packet cuts the old packet short and starts a new one.

The receiver pushes back on dedicated reverse lines, and the buffer threshold is set so that flits still in flight have room. The top level exposes both ends, so two instances can be cross-wired across a link, or one instance can be looped back on itself.

Top module: `link_framer_top`

## Requirements
- R1: After reset the transmit channel carries type 00 with zero data, `snk_valid` is low, and `rx_fc` is 0.
- R2: The first word accepted while no packet is open is sent as a routing-tag flit (type 01) on the cycle after acceptance, and it carries the word's data. `src_last` on that word is ignored.
- R3: After the tag, an accepted word with `src_last` low is sent as a payload flit (type 10). An accepted word with `src_last` high is sent as an end-of-packet flit (type 11) and closes the packet. Control bits [3:2] are always 0.
- R4: While any bit of `tx_fc` is high, `src_ready` is low and the next flit is idle. The packet position is kept, so the next accepted word continues the same packet.
- R5: Any cycle without an accepted word produces an idle flit (type 00) with data 0.
- R6: Received tag, payload and end-of-packet flits reach the sink in arrival order. `snk_head` is set for a tag and `snk_last` is set for an end-of-packet flit. Idle flits are never delivered.
- R7: A payload or end-of-packet flit received while no packet is open is discarded.
- R8: A tag received while a packet is open is delivered with `snk_abort` high, and it opens the new packet.
- R9: All four `rx_fc` lines are high exactly when buffer occupancy is at least DEPTH-2. With `tx_fc` fed from `rx_fc` the buffer never overflows.
- R10: While `snk_valid` is high and `snk_ready` is low, the sink word stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared link clock |
| rst_n | input | 1 | Active-low reset |
| src_valid | input | 1 | Source word valid |
| src_last | input | 1 | Source word closes the packet |
| src_data | input | 16 | Source word |
| src_ready | output | 1 | Framer accepts a word this cycle |
| tx_data | output | 16 | Outgoing flit data |
| tx_ctrl | output | 4 | Outgoing control: [1:0] flit type, [3:2] zero |
| tx_fc | input | 4 | Reverse flow-control lines seen by the transmitter |
| rx_data | input | 16 | Incoming flit data |
| rx_ctrl | input | 4 | Incoming control: [1:0] flit type |
| rx_fc | output | 4 | Reverse flow-control lines driven by the receiver |
| snk_valid | output | 1 | Sink word available |
| snk_data | output | 16 | Sink word data |
| snk_head | output | 1 | Sink word was a routing tag |
| snk_last | output | 1 | Sink word was an end-of-packet flit |
| snk_abort | output | 1 | Tag that cut the previous packet short |
| snk_ready | input | 1 | Sink consumes the word |

## Verification
The bench checks that a stop arriving mid-packet delays the stream without restarting it. A framer that lost its position would send the next word as a fresh tag. The bench also checks that `src_last` on a tag word does not close a one-word packet; getting this wrong would produce an end-of-packet flit with no payload before it. On the receive side, orphan payload and end-of-packet flits must be dropped, and a tag arriving mid-packet must carry the abort mark. A deframer that missed either would hand the sink stray words or merge two packets. The bench also steps the buffer through the stop threshold one flit at a time. It then loops the link back under sustained back-pressure, where an off-by-one in the threshold would overflow the buffer or lose words.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
    parameter int DATA_W = 16;
    parameter int CTRL_W = 4;
    parameter int FC_W   = 4;

    typedef enum logic [1:0] {
        FT_IDLE = 2'b00,
        FT_TAG  = 2'b01,
        FT_BODY = 2'b10,
        FT_TAIL = 2'b11
    } flit_t;

    typedef struct packed {
        logic              abort;
        logic              head;
        logic              last;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    localparam int RX_WORD_W = $bits(rx_word_t);
endpackage

// File: rtl/lnk_tx_framer.sv
module lnk_tx_framer
    import lnk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic              src_last,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    input  logic [FC_W-1:0]   fc_in,
    output logic [DATA_W-1:0] ch_data,
    output logic [CTRL_W-1:0] ch_ctrl
);
    typedef struct packed {
        logic              in_pkt;
        flit_t             ftype;
        logic [DATA_W-1:0] data;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      stop_w;
    logic      take_w;

    always_comb begin
        stop_w    = |fc_in;
        src_ready = !stop_w;
        take_w    = src_valid && !stop_w;
        st_d       = st_q;
        st_d.ftype = FT_IDLE;
        st_d.data  = '0;
        if (take_w) begin
            st_d.data = src_data;
            if (!st_q.in_pkt) begin
                st_d.ftype  = FT_TAG;
                st_d.in_pkt = 1'b1;
            end else if (src_last) begin
                st_d.ftype  = FT_TAIL;
                st_d.in_pkt = 1'b0;
            end else begin
                st_d.ftype  = FT_BODY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{in_pkt: 1'b0, ftype: FT_IDLE, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ch_data = st_q.data;
    assign ch_ctrl = {{(CTRL_W-2){1'b0}}, st_q.ftype};

    AST_STOP_GIVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|fc_in) |=> (ch_ctrl[1:0] == FT_IDLE)); // R4
    AST_IDLE_CARRIES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ctrl[1:0] == FT_IDLE) |-> (ch_data == '0)); // R5
    AST_BODY_INSIDE_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ctrl[1:0] == FT_BODY) |-> st_q.in_pkt); // R3
endmodule

// File: rtl/lnk_flit_fifo.sv
module lnk_flit_fifo #(
    parameter int W     = 19,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         not_empty,
    output logic         full,
    output logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          p_d, p_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (int'(p) == DEPTH-1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push = push && !full;
        do_pop  = pop && not_empty;
        p_d     = p_q;
        if (do_push) p_d.wr = bump(p_q.wr);
        if (do_pop)  p_d.rd = bump(p_q.rd);
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wr] <= wdata;
    end

    assign rdata     = mem_q[p_q.rd];
    assign not_empty = (p_q.cnt != '0);
    assign full      = (int'(p_q.cnt) == DEPTH);
    assign occ       = p_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push); // R9
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (not_empty && !pop) |=> $stable(rdata)); // R10
endmodule

// File: rtl/lnk_rx_deframer.sv
module lnk_rx_deframer
    import lnk_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int MARGIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ch_data,
    input  logic [CTRL_W-1:0] ch_ctrl,
    input  logic [$clog2(DEPTH+1)-1:0] occ,
    output logic              push,
    output rx_word_t          push_word,
    output logic [FC_W-1:0]   fc_out
);
    localparam int STOP_AT = DEPTH - MARGIN;

    typedef struct packed {
        logic in_pkt;
    } rx_state_t;

    rx_state_t st_d, st_q;
    flit_t     ftype_w;
    logic      stop_w;

    always_comb begin
        ftype_w   = flit_t'(ch_ctrl[1:0]);
        st_d      = st_q;
        push      = 1'b0;
        push_word = '{abort: 1'b0, head: 1'b0, last: 1'b0, data: ch_data};
        unique case (ftype_w)
            FT_TAG: begin
                push            = 1'b1;
                push_word.head  = 1'b1;
                push_word.abort = st_q.in_pkt;
                st_d.in_pkt     = 1'b1;
            end
            FT_BODY: begin
                push = st_q.in_pkt;
            end
            FT_TAIL: begin
                push           = st_q.in_pkt;
                push_word.last = 1'b1;
                st_d.in_pkt    = 1'b0;
            end
            default: begin
            end
        endcase
        stop_w = (int'(occ) >= STOP_AT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{in_pkt: 1'b0};
        else        st_q <= st_d;
    end

    assign fc_out = {FC_W{stop_w}};

    AST_ORPHAN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.in_pkt && (ch_ctrl[1:0] == FT_BODY || ch_ctrl[1:0] == FT_TAIL)) |-> !push); // R7
    AST_NO_IDLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ctrl[1:0] == FT_IDLE) |-> !push); // R6
endmodule

// File: rtl/link_framer_top.sv
module link_framer_top
    import lnk_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int MARGIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic              src_last,
    input  logic [15:0]       src_data,
    output logic              src_ready,
    output logic [15:0]       tx_data,
    output logic [3:0]        tx_ctrl,
    input  logic [3:0]        tx_fc,
    input  logic [15:0]       rx_data,
    input  logic [3:0]        rx_ctrl,
    output logic [3:0]        rx_fc,
    output logic              snk_valid,
    output logic [15:0]       snk_data,
    output logic              snk_head,
    output logic              snk_last,
    output logic              snk_abort,
    input  logic              snk_ready
);
    localparam int CW = $clog2(DEPTH+1);

    logic          push_w;
    rx_word_t      push_word_w;
    logic [RX_WORD_W-1:0] rd_raw_w;
    rx_word_t      rd_word_w;
    logic          full_w;
    logic [CW-1:0] occ_w;

    lnk_tx_framer u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .src_last  (src_last),
        .src_data  (src_data),
        .src_ready (src_ready),
        .fc_in     (tx_fc),
        .ch_data   (tx_data),
        .ch_ctrl   (tx_ctrl)
    );

    lnk_rx_deframer #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_data   (rx_data),
        .ch_ctrl   (rx_ctrl),
        .occ       (occ_w),
        .push      (push_w),
        .push_word (push_word_w),
        .fc_out    (rx_fc)
    );

    lnk_flit_fifo #(.W(RX_WORD_W), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_w),
        .wdata     (push_word_w),
        .pop       (snk_ready),
        .rdata     (rd_raw_w),
        .not_empty (snk_valid),
        .full      (full_w),
        .occ       (occ_w)
    );

    assign rd_word_w = rx_word_t'(rd_raw_w);
    assign snk_data  = rd_word_w.data;
    assign snk_head  = rd_word_w.head;
    assign snk_last  = rd_word_w.last;
    assign snk_abort = rd_word_w.abort;

    AST_FC_TRACKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        full_w |-> (rx_fc == 4'hF)); // R9
endmodule

// File: tb/link_framer_top_tb_top.sv
module link_framer_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        src_valid = 1'b0, src_last = 1'b0, src_ready;
    logic [15:0] src_data = '0;
    logic [15:0] tx_data;
    logic [3:0]  tx_ctrl, tx_fc, rx_fc;
    logic [3:0]  bench_fc = '0;
    logic        fc_loop = 1'b0;
    logic        inj_en = 1'b0;
    logic [15:0] inj_data = '0;
    logic [1:0]  inj_type = 2'b00;
    logic [15:0] rx_data;
    logic [3:0]  rx_ctrl;
    logic        snk_valid, snk_head, snk_last, snk_abort;
    logic [15:0] snk_data;
    logic        snk_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    assign tx_fc   = fc_loop ? rx_fc : bench_fc;
    assign rx_data = inj_en ? inj_data : tx_data;
    assign rx_ctrl = inj_en ? {2'b00, inj_type} : tx_ctrl;

    link_framer_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_last(src_last), .src_data(src_data), .src_ready(src_ready),
        .tx_data(tx_data), .tx_ctrl(tx_ctrl), .tx_fc(tx_fc),
        .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_fc(rx_fc),
        .snk_valid(snk_valid), .snk_data(snk_data), .snk_head(snk_head),
        .snk_last(snk_last), .snk_abort(snk_abort), .snk_ready(snk_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        v;
        logic        l;
        logic        s;
        logic [15:0] d;
        logic [1:0]  et;
        logic [15:0] ed;
        logic        er;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{1'b1, 1'b0, 1'b0, 16'hA001, 2'b01, 16'hA001, 1'b1},
        '{1'b1, 1'b0, 1'b0, 16'hA002, 2'b10, 16'hA002, 1'b1},
        '{1'b1, 1'b0, 1'b1, 16'hA003, 2'b00, 16'h0000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 16'hFFFF, 2'b00, 16'h0000, 1'b1},
        '{1'b1, 1'b0, 1'b0, 16'hA003, 2'b10, 16'hA003, 1'b1},
        '{1'b1, 1'b1, 1'b0, 16'hA004, 2'b11, 16'hA004, 1'b1},
        '{1'b1, 1'b1, 1'b0, 16'hB001, 2'b01, 16'hB001, 1'b1},
        '{1'b1, 1'b1, 1'b0, 16'hB002, 2'b11, 16'hB002, 1'b1},
        '{1'b1, 1'b0, 1'b1, 16'hC001, 2'b00, 16'h0000, 1'b0},
        '{1'b1, 1'b0, 1'b0, 16'hC001, 2'b01, 16'hC001, 1'b1},
        '{1'b1, 1'b1, 1'b0, 16'hC002, 2'b11, 16'hC002, 1'b1}
    };

    task automatic inj(input logic [1:0] t, input logic [15:0] d);
        @(negedge clk);
        inj_type = t;
        inj_data = d;
        @(negedge clk);
        inj_type = 2'b00;
        inj_data = 16'h0;
    endtask

    task automatic pop_chk(input logic [15:0] d, input logic h, input logic l, input logic a, input string req);
        @(negedge clk);
        chk(snk_valid == 1'b1, req, {31'd0, snk_valid}, 32'd1);
        chk(snk_data == d, req, {16'd0, snk_data}, {16'd0, d});
        chk({snk_head, snk_last, snk_abort} == {h, l, a}, req,
            {29'd0, snk_head, snk_last, snk_abort}, {29'd0, h, l, a});
        snk_ready = 1'b1;
        @(negedge clk);
        snk_ready = 1'b0;
    endtask

    localparam int NLOOP = 12;
    bit saw_stop = 1'b0;

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_ctrl == 4'h0 && tx_data == 16'h0, "R1", {12'd0, tx_ctrl, tx_data}, 32'd0);
        chk(snk_valid == 1'b0, "R1", {31'd0, snk_valid}, 32'd0);
        chk(rx_fc == 4'h0, "R1", {28'd0, rx_fc}, 32'd0);

        // Table walk: transmit framing, stop and idle (R2 R3 R4 R5), loopback drains to sink
        snk_ready = 1'b1;
        for (int i = 0; i < 11; i++) begin
            src_valid = VEC[i].v;
            src_last  = VEC[i].l;
            src_data  = VEC[i].d;
            bench_fc  = VEC[i].s ? 4'b0100 : 4'b0000;
            #1;
            chk(src_ready == VEC[i].er, "R4", {31'd0, src_ready}, {31'd0, VEC[i].er});
            @(negedge clk);
            chk(tx_ctrl == {2'b00, VEC[i].et}, "R2/R3/R4/R5", {28'd0, tx_ctrl}, {28'd0, 2'b00, VEC[i].et});
            chk(tx_data == VEC[i].ed, "R2/R3/R5", {16'd0, tx_data}, {16'd0, VEC[i].ed});
        end
        src_valid = 1'b0;
        bench_fc  = 4'h0;
        @(negedge clk);
        chk(tx_ctrl == 4'h0 && tx_data == 16'h0, "R5", {12'd0, tx_ctrl, tx_data}, 32'd0);
        repeat (6) @(negedge clk);
        chk(snk_valid == 1'b0, "R6", {31'd0, snk_valid}, 32'd0);
        snk_ready = 1'b0;

        // Receive framing: orphans, abort, idle (R6 R7 R8)
        inj_en = 1'b1;
        inj(2'b11, 16'h1111);
        inj(2'b10, 16'h2222);
        @(negedge clk);
        chk(snk_valid == 1'b0, "R7", {31'd0, snk_valid}, 32'd0);
        inj(2'b01, 16'h3333);
        inj(2'b10, 16'h4444);
        inj(2'b01, 16'h5555);
        inj(2'b11, 16'h6666);
        inj(2'b00, 16'h7777);
        inj(2'b10, 16'h8888);
        // R10 word held while not consumed
        @(negedge clk);
        chk(snk_data == 16'h3333, "R10", {16'd0, snk_data}, 32'h3333);
        @(negedge clk);
        chk(snk_data == 16'h3333 && snk_valid, "R10", {16'd0, snk_data}, 32'h3333);
        pop_chk(16'h3333, 1'b1, 1'b0, 1'b0, "R6");
        pop_chk(16'h4444, 1'b0, 1'b0, 1'b0, "R6");
        pop_chk(16'h5555, 1'b1, 1'b0, 1'b1, "R8");
        pop_chk(16'h6666, 1'b0, 1'b1, 1'b0, "R6");
        @(negedge clk);
        chk(snk_valid == 1'b0, "R7", {31'd0, snk_valid}, 32'd0);

        // Stop threshold (R9): DEPTH 8, stop at 6
        inj(2'b01, 16'h9000);
        for (int k = 1; k < 5; k++) inj(2'b10, 16'h9000 + 16'(k));
        chk(rx_fc == 4'h0, "R9", {28'd0, rx_fc}, 32'h0);
        inj(2'b10, 16'h9005);
        chk(rx_fc == 4'hF, "R9", {28'd0, rx_fc}, 32'hF);
        pop_chk(16'h9000, 1'b1, 1'b0, 1'b0, "R9");
        chk(rx_fc == 4'h0, "R9", {28'd0, rx_fc}, 32'h0);
        inj(2'b11, 16'h9006);
        snk_ready = 1'b1;
        repeat (8) @(negedge clk);
        snk_ready = 1'b0;
        chk(snk_valid == 1'b0, "R9", {31'd0, snk_valid}, 32'd0);

        // Loopback under back-pressure (R6 R9)
        inj_en  = 1'b0;
        fc_loop = 1'b1;
        fork
            begin
                for (int i = 0; i < NLOOP; i++) begin
                    @(negedge clk);
                    src_valid = 1'b1;
                    src_data  = 16'hD000 + 16'(i);
                    src_last  = (i == NLOOP-1);
                    while (!src_ready) @(negedge clk);
                    @(posedge clk);
                end
                @(negedge clk);
                src_valid = 1'b0;
                src_last  = 1'b0;
            end
            begin
                int j = 0;
                repeat (14) begin
                    @(negedge clk);
                    if (rx_fc == 4'hF) saw_stop = 1'b1;
                end
                while (j < NLOOP) begin
                    @(negedge clk);
                    if (snk_valid) begin
                        chk(snk_data == 16'hD000 + 16'(j), "R6", {16'd0, snk_data}, {16'd0, 16'hD000 + 16'(j)});
                        chk({snk_head, snk_last} == {j == 0, j == NLOOP-1}, "R6",
                            {30'd0, snk_head, snk_last}, {30'd0, j == 0, j == NLOOP-1});
                        snk_ready = 1'b1;
                        j++;
                    end else begin
                        snk_ready = 1'b0;
                    end
                end
                @(negedge clk);
                snk_ready = 1'b0;
            end
        join
        chk(saw_stop, "R9", {31'd0, saw_stop}, 32'd1);
        @(negedge clk);
        chk(snk_valid == 1'b0, "R6", {31'd0, snk_valid}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule